// File: doc/BRIEF.md
# Fan PWM Channel Controller

This block drives one fan PWM pin. An 8-bit configuration register holds four fields: the spin-up timeout code, the slow-ramp flag, the output inversion flag and the behaviour code. The behaviour code picks where the duty cycle comes from. The choices are one of three per-channel temperature duty requests, the larger of two of them, the largest of all three, a manual duty register, forced full speed, or off. The chosen duty goes to a free-running 8-bit PWM comparator. Its output can be inverted before it reaches the pin.

When the selected duty moves from zero to a nonzero value, the block enters a spin-up phase, and this includes the first cycle after reset. During spin-up the effective duty reads 255 until two rising edges of the synchronised tachometer input have been seen. If a timeout is programmed and that many millisecond ticks pass first, the phase ends and the fan-fault flag rises.

The block does not map temperature to duty, measure the tachometer period or generate ramp slopes. It only reports a ramp-scale factor, which ramp logic elsewhere in the chip uses.

Top module: `fan_pwm_channel`

## Requirements
- R1: After reset the configuration reads 0x82. A write strobe loads the configuration on the next clock edge, unless the lock input is high, in which case the write is ignored and the stored value is kept.
- R2: Behaviour code (bits [7:5]) selects the duty: 000 channel-1 request, 001 local request, 010 channel-2 request, 011 constant 255, 101 the larger of local and channel-2, 110 the largest of all three, 111 the manual register.
- R3: Behaviour code 100 gives an effective duty of 0, starts no spin-up, and holds the pin at its inactive level: low when not inverted, high when inverted.
- R4: When the selected duty goes from 0 to nonzero, the effective duty reads 255 in that same cycle, and it stays at 255 while the spin-up phase lasts.
- R5: The tachometer input passes through two synchronising flip-flops. Spin-up ends, and the effective duty returns to the selected value, only after two rising edges of the synchronised signal. One edge alone is not enough.
- R6: Timeout code (bits [2:0]) gives a limit in millisecond ticks: 001=100, 010=250, 011=400, 100=667, 101=1000, 110=2000, 111=4000. If the limit is reached during spin-up, the fan-fault flag is set and spin-up ends. Code 000 never times out.
- R7: The fan-fault flag stays set until the next spin-up phase starts. At that point it clears.
- R8: Over any 256 consecutive clocks with a steady duty D, the uninverted pin is high for D clocks. A duty of 255 gives a pin that is high all the time.
- R9: Inversion flag (bit 4) set complements the pin, so 255 gives a pin that is low all the time and D gives 256-D high clocks out of 256.
- R10: The ramp-scale output reads 4 when the slow flag (bit 3) is set and 1 when it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_lock | input | 1 | Makes the configuration read-only while high |
| duty_ch1 | input | 8 | Duty request from temperature channel 1 |
| duty_local | input | 8 | Duty request from the local temperature channel |
| duty_ch2 | input | 8 | Duty request from temperature channel 2 |
| duty_manual | input | 8 | Manual duty register value |
| tach_in | input | 1 | Asynchronous tachometer pulse input |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| pwm_out | output | 1 | PWM pin |
| fan_fault | output | 1 | Spin-up timeout fault flag |
| duty_eff | output | 8 | Effective duty applied to the comparator |
| ramp_scale | output | 3 | Ramp period multiplier (1 or 4) |
| cfg_q | output | 8 | Current configuration value |

## Verification
Some rules hold on every cycle and are checked by assertions:
- a locked configuration never changes;
- the off behaviour always yields a zero effective duty;
- a fault rises only under a nonzero timeout code;
- spin-up ends without a fault only on a synchronised tachometer edge;
- a duty of 255 drives the pin to its full level, after inversion.

Other behaviours need the bench's scenarios:
- the exact tick count at which each timeout fires;
- that a single tachometer edge does not end spin-up;
- the duty-to-high-time ratio over a PWM period;
- the source selection under random requests with ties;
- the fault clearing on the next spin-up.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  localparam int DUTY_W = 8;
  localparam int MS_W   = 12;

  typedef enum logic [2:0] {
    BH_CH1     = 3'b000,
    BH_LOCAL   = 3'b001,
    BH_CH2     = 3'b010,
    BH_FULL    = 3'b011,
    BH_OFF     = 3'b100,
    BH_MAX_LC2 = 3'b101,
    BH_MAX_ALL = 3'b110,
    BH_MANUAL  = 3'b111
  } behav_e;

  typedef struct packed {
    behav_e     behav;
    logic       inv;
    logic       slow;
    logic [2:0] tmo;
  } cfg_t;

  typedef enum logic [1:0] {
    SU_IDLE = 2'd0,
    SU_SPIN = 2'd1,
    SU_RUN  = 2'd2
  } spin_e;

  function automatic logic [MS_W-1:0] tmo_limit(input logic [2:0] code);
    logic [MS_W-1:0] lim;
    case (code)
      3'd1:    lim = MS_W'(100);
      3'd2:    lim = MS_W'(250);
      3'd3:    lim = MS_W'(400);
      3'd4:    lim = MS_W'(667);
      3'd5:    lim = MS_W'(1000);
      3'd6:    lim = MS_W'(2000);
      3'd7:    lim = MS_W'(4000);
      default: lim = '0;
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/fpc_tach_sync.sv
module fpc_tach_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tach_in,
  output logic tach_rise
);

  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;
  logic [CHAIN-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN-2:0], tach_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign tach_rise = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/fpc_duty_sel.sv
module fpc_duty_sel
  import fpc_pkg::*;
#(
  parameter int DW = DUTY_W
) (
  input  behav_e        behav,
  input  logic [DW-1:0] req_ch1,
  input  logic [DW-1:0] req_local,
  input  logic [DW-1:0] req_ch2,
  input  logic [DW-1:0] req_manual,
  output logic [DW-1:0] sel_duty
);

  logic [DW-1:0] max_lc2;
  logic [DW-1:0] max_all;

  always_comb begin
    max_lc2 = (req_local > req_ch2) ? req_local : req_ch2;
    max_all = (req_ch1 > max_lc2) ? req_ch1 : max_lc2;
  end

  always_comb begin
    case (behav)
      BH_CH1:     sel_duty = req_ch1;
      BH_LOCAL:   sel_duty = req_local;
      BH_CH2:     sel_duty = req_ch2;
      BH_FULL:    sel_duty = '1;
      BH_OFF:     sel_duty = '0;
      BH_MAX_LC2: sel_duty = max_lc2;
      BH_MAX_ALL: sel_duty = max_all;
      default:    sel_duty = req_manual;
    endcase
  end

endmodule

// File: rtl/fpc_spinup.sv
module fpc_spinup
  import fpc_pkg::*;
#(
  parameter int DW = DUTY_W,
  parameter int MW = MS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] duty_in,
  input  logic [2:0]    tmo_code,
  input  logic          ms_tick,
  input  logic          tach_rise,
  output logic [DW-1:0] duty_out,
  output logic          fault
);

  spin_e         state_q, state_d;
  logic          edge_q, edge_d;
  logic [MW-1:0] ms_q, ms_d;
  logic          fault_q, fault_d;

  logic          nz;
  logic          start_now;
  logic          spin_active;
  logic          edges_done;
  logic          timed_out;
  logic [MW-1:0] limit;

  always_comb begin
    nz          = (duty_in != '0);
    start_now   = (state_q == SU_IDLE) && nz;
    spin_active = nz && (state_q != SU_RUN);
    limit       = MW'(tmo_limit(tmo_code));
    edges_done  = (state_q == SU_SPIN) && tach_rise && edge_q;
    timed_out   = (state_q == SU_SPIN) && !edges_done && ms_tick &&
                  (tmo_code != 3'd0) && (ms_q == limit - MW'(1));
  end

  always_comb begin
    state_d = state_q;
    edge_d  = edge_q;
    ms_d    = ms_q;
    fault_d = fault_q;
    if (!nz) begin
      state_d = SU_IDLE;
    end else begin
      case (state_q)
        SU_IDLE: begin
          state_d = SU_SPIN;
          edge_d  = 1'b0;
          ms_d    = '0;
          fault_d = 1'b0;
        end
        SU_SPIN: begin
          if (edges_done) begin
            state_d = SU_RUN;
          end else if (timed_out) begin
            state_d = SU_RUN;
            fault_d = 1'b1;
          end else begin
            if (tach_rise) edge_d = 1'b1;
            if (ms_tick)   ms_d   = ms_q + MW'(1);
          end
        end
        default: state_d = SU_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SU_IDLE;
      edge_q  <= 1'b0;
      ms_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      edge_q  <= edge_d;
      ms_q    <= ms_d;
      fault_q <= fault_d;
    end
  end

  assign duty_out = spin_active ? {DW{1'b1}} : duty_in;
  assign fault    = fault_q;

  assert_fault_needs_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> ($past(tmo_code) != 3'd0));

  assert_clean_exit_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == SU_SPIN && state_q == SU_RUN && !fault_q) |-> $past(tach_rise));

  assert_start_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SU_IDLE && duty_in != '0) |-> (duty_out == {DW{1'b1}}));

endmodule

// File: rtl/fpc_pwm_gen.sv
module fpc_pwm_gen #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] duty,
  input  logic          invert,
  output logic          pwm
);

  logic [DW-1:0] cnt_q, cnt_d;
  logic          pwm_q, pwm_d;
  logic          alive_q;
  logic          cnt_en;
  logic          raw;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_en ? cnt_q + DW'(1) : cnt_q;
    raw    = (duty == {DW{1'b1}}) || (cnt_q < duty);
    pwm_d  = raw ^ invert;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pwm_q   <= 1'b0;
      alive_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pwm_q   <= pwm_d;
      alive_q <= 1'b1;
    end
  end

  assign pwm = pwm_q;

  assert_full_duty_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alive_q && $past(duty) == {DW{1'b1}}) |-> (pwm_q == !$past(invert)));

  assert_zero_duty_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alive_q && $past(duty) == '0) |-> (pwm_q == $past(invert)));

endmodule

// File: rtl/fan_pwm_channel.sv
module fan_pwm_channel
  import fpc_pkg::*;
#(
  parameter int         DW          = DUTY_W,
  parameter int         MW          = MS_W,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CFG_RESET   = 8'h82
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_wdata,
  input  logic          cfg_lock,
  input  logic [DW-1:0] duty_ch1,
  input  logic [DW-1:0] duty_local,
  input  logic [DW-1:0] duty_ch2,
  input  logic [DW-1:0] duty_manual,
  input  logic          tach_in,
  input  logic          ms_tick,
  output logic          pwm_out,
  output logic          fan_fault,
  output logic [DW-1:0] duty_eff,
  output logic [2:0]    ramp_scale,
  output logic [7:0]    cfg_q
);

  cfg_t          cfg_r, cfg_d;
  logic          cfg_en;
  logic          tach_rise;
  logic [DW-1:0] sel_duty;

  always_comb begin
    cfg_en = cfg_wr && !cfg_lock;
    cfg_d  = cfg_en ? cfg_t'(cfg_wdata) : cfg_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_r <= cfg_t'(CFG_RESET);
    else        cfg_r <= cfg_d;
  end

  fpc_tach_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .tach_in   (tach_in),
    .tach_rise (tach_rise)
  );

  fpc_duty_sel #(.DW(DW)) u_sel (
    .behav      (cfg_r.behav),
    .req_ch1    (duty_ch1),
    .req_local  (duty_local),
    .req_ch2    (duty_ch2),
    .req_manual (duty_manual),
    .sel_duty   (sel_duty)
  );

  fpc_spinup #(.DW(DW), .MW(MW)) u_spin (
    .clk       (clk),
    .rst_n     (rst_n),
    .duty_in   (sel_duty),
    .tmo_code  (cfg_r.tmo),
    .ms_tick   (ms_tick),
    .tach_rise (tach_rise),
    .duty_out  (duty_eff),
    .fault     (fan_fault)
  );

  fpc_pwm_gen #(.DW(DW)) u_pwm (
    .clk    (clk),
    .rst_n  (rst_n),
    .duty   (duty_eff),
    .invert (cfg_r.inv),
    .pwm    (pwm_out)
  );

  assign ramp_scale = cfg_r.slow ? 3'd4 : 3'd1;
  assign cfg_q      = cfg_r;

  assert_locked_cfg_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lock |=> $stable(cfg_q));

  assert_off_gives_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_r.behav == BH_OFF) |-> (duty_eff == '0));

endmodule

// File: tb/test_fan_pwm_channel.sv
module test_fan_pwm_channel;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       cfg_lock = 1'b0;
  logic [7:0] d1 = 8'd0, dl = 8'd0, d2 = 8'd0, dm = 8'd0;
  logic       tach = 1'b0;
  logic       tick = 1'b0;
  logic       pwm_out, fan_fault;
  logic [7:0] duty_eff, cfg_q;
  logic [2:0] ramp_scale;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fan_pwm_channel i_fan_pwm_channel (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_lock(cfg_lock), .duty_ch1(d1), .duty_local(dl), .duty_ch2(d2),
    .duty_manual(dm), .tach_in(tach), .ms_tick(tick), .pwm_out(pwm_out),
    .fan_fault(fan_fault), .duty_eff(duty_eff), .ramp_scale(ramp_scale),
    .cfg_q(cfg_q)
  );

  function automatic int exp_duty(int b, int c1, int lo, int c2, int man);
    int m;
    case (b)
      0: return c1;
      1: return lo;
      2: return c2;
      3: return 255;
      4: return 0;
      5: return (lo > c2) ? lo : c2;
      6: begin m = (lo > c2) ? lo : c2; return (c1 > m) ? c1 : m; end
      default: return man;
    endcase
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wcfg(logic [7:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic tach_pulse();
    tach = 1'b1; step(4);
    tach = 1'b0; step(4);
  endtask

  task automatic count_high(output int n);
    n = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (pwm_out) n++;
    end
  endtask

  task automatic ticks(int n);
    tick = 1'b1; step(n); tick = 1'b0;
  endtask

  initial begin
    int hc;
    int b;
    int lst[7] = '{0, 1, 2, 3, 5, 6, 7};
    void'($urandom(32'h5eed_f00d));
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 reset cfg", cfg_q, 8'h82);
    chk("R3 reset off duty", duty_eff, 0);
    chk("R7 reset fault", fan_fault, 0);
    chk("R10 reset ramp", ramp_scale, 1);

    // manual mode, no timeout: spin-up from zero
    dm = 8'd100;
    wcfg(8'hE0);
    chk("R4 spin full", duty_eff, 255);
    tach_pulse();
    chk("R5 one edge still spinning", duty_eff, 255);
    tach_pulse();
    step(2);
    chk("R5 two edges release", duty_eff, 100);
    chk("R6 no fault", fan_fault, 0);

    // lock
    cfg_lock = 1'b1;
    wcfg(8'h00);
    chk("R1 locked write ignored", cfg_q, 8'hE0);
    chk("R1 locked duty unchanged", duty_eff, 100);
    cfg_lock = 1'b0;

    // ramp scale
    wcfg(8'hE8);
    chk("R10 slow ramp", ramp_scale, 4);
    wcfg(8'hE0);
    chk("R10 normal ramp", ramp_scale, 1);

    // directed ties for max modes
    d1 = 8'd77; dl = 8'd77; d2 = 8'd77;
    wcfg(8'hC0);
    chk("R2 max all tie", duty_eff, 77);
    wcfg(8'hA0);
    chk("R2 max lc2 tie", duty_eff, 77);

    // random source selection, all requests nonzero
    for (int it = 0; it < 40; it++) begin
      b  = lst[$urandom % 7];
      d1 = 8'(1 + $urandom % 255);
      dl = 8'(1 + $urandom % 255);
      d2 = 8'(1 + $urandom % 255);
      dm = 8'(1 + $urandom % 255);
      wcfg({3'(b), 5'b0});
      chk("R2 behaviour select", duty_eff, exp_duty(b, d1, dl, d2, dm));
    end

    // PWM ratio and inversion
    dm = 8'd64;
    wcfg(8'hE0);
    step(2);
    count_high(hc);
    chk("R8 duty 64 high count", hc, 64);
    dm = 8'd255; step(2);
    count_high(hc);
    chk("R8 duty 255 always high", hc, 256);
    wcfg(8'hF0);
    dm = 8'd64; step(2);
    count_high(hc);
    chk("R9 inverted 64", hc, 192);
    dm = 8'd255; step(2);
    count_high(hc);
    chk("R9 inverted 255 always low", hc, 0);

    // off behaviour
    wcfg(8'h90);
    step(2);
    chk("R3 off duty", duty_eff, 0);
    count_high(hc);
    chk("R3 off inverted idle high", hc, 256);
    wcfg(8'h80);
    step(2);
    count_high(hc);
    chk("R3 off idle low", hc, 0);
    chk("R3 no spin fault", fan_fault, 0);

    // timeout code 001 = 100 ticks
    dm = 8'd50;
    wcfg(8'hE1);
    chk("R4 spin after off", duty_eff, 255);
    step(1);
    ticks(99);
    chk("R6 99 ticks no fault", fan_fault, 0);
    chk("R6 99 ticks still full", duty_eff, 255);
    ticks(1);
    chk("R6 fault at 100 ticks", fan_fault, 1);
    chk("R6 released after timeout", duty_eff, 50);

    // fault clears on next spin-up, code 000 never times out
    dm = 8'd0; step(2);
    wcfg(8'hE0);
    dm = 8'd60; step(1);
    chk("R7 fault cleared at new spin", fan_fault, 0);
    chk("R4 spin again", duty_eff, 255);
    ticks(5000);
    chk("R6 code 000 no fault", fan_fault, 0);
    chk("R6 code 000 still spinning", duty_eff, 255);
    tach_pulse(); tach_pulse(); step(2);
    chk("R5 release after edges", duty_eff, 60);

    // timeout code 111 = 4000 ticks
    dm = 8'd0; step(2);
    wcfg(8'hE7);
    dm = 8'd70; step(1);
    ticks(3999);
    chk("R6 3999 ticks no fault", fan_fault, 0);
    ticks(1);
    chk("R6 fault at 4000 ticks", fan_fault, 1);
    chk("R6 release at 4000", duty_eff, 70);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule